// File: doc/BRIEF.md
# No-Wait-State Synchronous SRAM

This block is a synthesizable synchronous memory whose bus can carry a read or a write on every clock. Address, control and write data are captured on the rising clock edge. Reads are flow-through: a read loaded at one edge presents its word, with a valid flag, during the very next cycle. The write data for a write loaded at one edge arrives at the following edge, together with that cycle's byte write enables. Because the data phase of a write falls one cycle after its address, a read can be issued in the cycle right after a write with no idle cycle between them. A read that hits the word being written in that cycle returns the freshly merged word.

Each operation is started by a load strobe and can be extended into a burst of up to four words by an advance strobe. During a burst the operation type stays the same as at the load, and the low two address bits step through either a linear (wrapping add) or an interleaved (XOR) order. Three chip enables gate selection at load time. An active-low clock enable suspends the whole block: while it is high, all internal state and both outputs stay frozen.

The array holds words of four 9-bit bytes. Depth, byte count and byte width are parameters.

Top module: `nowait_sram`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rvalid` is 0 and `rdata` is all zeros.
- R2: A load (`adv_ld_n`=0) with the chip selected and `wr_n`=1 at rising edge N is a read of `addr`. During the cycle after edge N, `rvalid` is 1 and `rdata` holds the addressed word.
- R3: A load with the chip selected and `wr_n`=0 at edge N is a write. At the next enabled edge, byte b of `wdata` (bits 9b+8..9b) is stored exactly when `byte_wr_n[b]`=0. Other bytes keep their old contents, and `rvalid` is 0 in the cycle after the load.
- R4: The chip is selected only when `cs_hi_a`=1, `cs_hi_b`=1 and `cs_lo_n`=0 at a load. Otherwise the cycle is a deselect. After a deselect, `rvalid` is 0 and `rdata` is zero, and no array word changes for as long as the deselect burst lasts.
- R5: With `burst_ilv`=0 captured at the load, the k-th advance after the load (k=1,2,3,...) uses low address bits (base+k) mod 4. The upper address bits stay those of the base.
- R6: With `burst_ilv`=1 captured at the load, the k-th advance uses low address bits base XOR (k mod 4). The upper address bits stay those of the base.
- R7: On an advance (`adv_ld_n`=1), `wr_n` and the three chip enables are ignored, and the operation type of the last load continues.
- R8: While `clk_en_n`=1, every input is ignored. `rdata`, `rvalid`, the burst position and the array do not change, and a write whose data phase is due waits for the next enabled edge.
- R9: A read whose address equals that of the write taking its data at the same edge returns the old word with the newly written bytes merged in.
- R10: Reads and writes may alternate on consecutive enabled edges with no idle cycle. Each one returns or stores the same data it would if issued alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the block |
| cs_hi_a | input | 1 | Active-high chip enable A |
| cs_hi_b | input | 1 | Active-high chip enable B |
| cs_lo_n | input | 1 | Active-low chip enable |
| adv_ld_n | input | 1 | Low: load a new operation; high: advance the burst |
| wr_n | input | 1 | At a load: low selects write, high selects read |
| burst_ilv | input | 1 | At a load: 1 interleaved burst order, 0 linear |
| byte_wr_n | input | NB | Active-low per-byte write enables for the data phase |
| addr | input | AW | Word address taken at a load |
| wdata | input | NB*BW | Write data for the data phase |
| rdata | output | NB*BW | Read word, zero when not valid |
| rvalid | output | 1 | High in the cycle that carries read data |

## Verification
Read results are due in the cycle right after the edge that loads or advances the read. Write data is taken at the enabled edge after the write's load or advance, so its effect can first be seen through a read loaded at that same edge. The bench drives inputs on the falling edge. It updates its reference model just after each rising edge, applying the pending write before forming the read result, and compares both outputs on the following falling edge. Suspended cycles leave the model untouched, so held outputs and delayed write data are checked in exactly the cycle they become due.

// File: rtl/nws_pkg.sv
package nws_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } nws_op_e;

endpackage

// File: rtl/nws_burst.sv
module nws_burst #(
  parameter int AW  = 6,
  parameter int BCW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic          ilv_in,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] next_addr,
  output logic [AW-1:0] cur_addr
);

  logic [AW-1:0]  base_q;
  logic [BCW-1:0] cnt_q;
  logic           ilv_q;
  logic [BCW-1:0] cnt_inc;
  logic [BCW-1:0] lo_next;

  assign cnt_inc = cnt_q + BCW'(1);

  always_comb begin
    if (ilv_q) lo_next = base_q[BCW-1:0] ^ cnt_inc;
    else       lo_next = base_q[BCW-1:0] + cnt_inc;
  end

  always_comb begin
    if (load) next_addr = addr_in;
    else      next_addr = {base_q[AW-1:BCW], lo_next};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_q    <= '0;
      ilv_q    <= 1'b0;
      cur_addr <= '0;
    end else if (en) begin
      cur_addr <= next_addr;
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
        ilv_q  <= ilv_in;
      end else begin
        cnt_q  <= cnt_inc;
      end
    end
  end

endmodule

// File: rtl/nws_ctrl.sv
module nws_ctrl
  import nws_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    load,
  input  logic    sel_ok,
  input  logic    wr_n,
  output nws_op_e next_op,
  output nws_op_e cur_op
);

  always_comb begin
    if (!load)       next_op = cur_op;
    else if (!sel_ok) next_op = OP_IDLE;
    else if (wr_n)    next_op = OP_READ;
    else              next_op = OP_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst)     cur_op <= OP_IDLE;
    else if (en) cur_op <= next_op;
  end

endmodule

// File: rtl/nws_array.sv
module nws_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wmask,
  input  logic [NB*BW-1:0] wdata,
  input  logic             rd,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata,
  output logic             rvalid
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_word;
  logic [DW-1:0] merged;
  logic          hit;

  assign mem_word = mem[raddr];
  assign hit      = wr && (waddr == raddr);

  // Write-through bypass: bytes written at this edge replace the stored ones.
  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*BW +: BW] = (hit && wmask[b]) ? wdata[b*BW +: BW]
                                                  : mem_word[b*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (en && wr) begin
      for (int b = 0; b < NB; b++) begin
        if (wmask[b]) mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (en) begin
      rvalid <= rd;
      rdata  <= rd ? merged : '0;
    end
  end

endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
  import nws_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             cs_hi_a,
  input  logic             cs_hi_b,
  input  logic             cs_lo_n,
  input  logic             adv_ld_n,
  input  logic             wr_n,
  input  logic             burst_ilv,
  input  logic [NB-1:0]    byte_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rdata,
  output logic             rvalid
);

  localparam int BCW = 2;

  logic          en;
  logic          load;
  logic          sel_ok;
  nws_op_e       next_op;
  nws_op_e       cur_op;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] cur_addr;

  assign en     = !clk_en_n;
  assign load   = !adv_ld_n;
  assign sel_ok = cs_hi_a && cs_hi_b && !cs_lo_n;

  nws_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .sel_ok  (sel_ok),
    .wr_n    (wr_n),
    .next_op (next_op),
    .cur_op  (cur_op)
  );

  nws_burst #(.AW(AW), .BCW(BCW)) i_burst (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .load      (load),
    .ilv_in    (burst_ilv),
    .addr_in   (addr),
    .next_addr (next_addr),
    .cur_addr  (cur_addr)
  );

  nws_array #(.AW(AW), .NB(NB), .BW(BW)) i_array (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .wr     (cur_op == OP_WRITE),
    .waddr  (cur_addr),
    .wmask  (~byte_wr_n),
    .wdata  (wdata),
    .rd     (next_op == OP_READ),
    .raddr  (next_addr),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

endmodule

// File: rtl/nws_sram_chk.sv
module nws_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          cs_hi_a,
  input logic          cs_hi_b,
  input logic          cs_lo_n,
  input logic          adv_ld_n,
  input logic          wr_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);

  logic sel;
  assign sel = cs_hi_a && cs_hi_b && !cs_lo_n;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rvalid && rdata == '0)); // R1

  AST_READ_LOAD_VALID: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld_n && sel && wr_n) |=> rvalid); // R2

  AST_WRITE_LOAD_NOVALID: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld_n && sel && !wr_n) |=> !rvalid); // R3

  AST_DESEL_NOVALID: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld_n && !sel) |=> !rvalid); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> rdata == '0); // R4

  AST_ADV_KEEPS_TYPE: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && adv_ld_n) |=> (rvalid == $past(rvalid))); // R7

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(rdata) && $stable(rvalid))); // R8

endmodule

bind nowait_sram nws_sram_chk #(.DW(NB*BW)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en_n (clk_en_n),
  .cs_hi_a  (cs_hi_a),
  .cs_hi_b  (cs_hi_b),
  .cs_lo_n  (cs_lo_n),
  .adv_ld_n (adv_ld_n),
  .wr_n     (wr_n),
  .rdata    (rdata),
  .rvalid   (rvalid)
);

// File: tb/test_nowait_sram.sv
`timescale 1ns/1ps
module test_nowait_sram;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          cs_hi_a = 1'b1;
  logic          cs_hi_b = 1'b1;
  logic          cs_lo_n = 1'b0;
  logic          adv_ld_n = 1'b1;
  logic          wr_n = 1'b1;
  logic          burst_ilv = 1'b0;
  logic [NB-1:0] byte_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0] m_mem [DEPTH];
  int            m_op = 0;      // 0 idle, 1 read, 2 write
  int            m_base = 0;
  int            m_cnt = 0;
  int            m_addr = 0;
  bit            m_ilv = 1'b0;
  bit            m_valid = 1'b0;
  logic [DW-1:0] m_data = '0;

  always #10 clk = ~clk;

  nowait_sram #(.AW(AW), .NB(NB), .BW(BW)) i_nowait_sram (
    .clk (clk), .rst (rst), .clk_en_n (clk_en_n),
    .cs_hi_a (cs_hi_a), .cs_hi_b (cs_hi_b), .cs_lo_n (cs_lo_n),
    .adv_ld_n (adv_ld_n), .wr_n (wr_n), .burst_ilv (burst_ilv),
    .byte_wr_n (byte_wr_n), .addr (addr), .wdata (wdata),
    .rdata (rdata), .rvalid (rvalid)
  );

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i) * 36'h123456789 ^ 36'hA5A5A5A5A;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rvalid !== m_valid || rdata !== m_data) begin
      errors++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, m_valid, m_data);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_op = 0; m_valid = 0; m_data = '0; m_cnt = 0; m_base = 0; m_addr = 0;
    end else if (!clk_en_n) begin
      if (m_op == 2)
        for (int b = 0; b < NB; b++)
          if (!byte_wr_n[b]) m_mem[m_addr][b*BW +: BW] = wdata[b*BW +: BW];
      if (!adv_ld_n) begin
        m_op   = (cs_hi_a && cs_hi_b && !cs_lo_n) ? (wr_n ? 1 : 2) : 0;
        m_base = int'(addr);
        m_cnt  = 0;
        m_ilv  = burst_ilv;
        m_addr = m_base;
      end else begin
        m_cnt  = (m_cnt + 1) % 4;
        m_addr = (m_base / 4) * 4 +
                 (m_ilv ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4));
      end
      m_valid = (m_op == 1);
      m_data  = m_valid ? m_mem[m_addr] : '0;
    end
  endtask

  // one cycle: inputs already set at a falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_in(bit ce_n, bit ld_n, bit w_n, bit ilv, int a,
                        logic [NB-1:0] bwn, logic [DW-1:0] wd);
    clk_en_n = ce_n; adv_ld_n = ld_n; wr_n = w_n; burst_ilv = ilv;
    addr = AW'(a); byte_wr_n = bwn; wdata = wd;
  endtask

  task automatic sel_all(bit a, bit b, bit c_n);
    cs_hi_a = a; cs_hi_b = b; cs_lo_n = c_n;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    rst = 1'b1;
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    set_in(0, 1, 1, 0, 0, '1, '0);
    cyc("R1");

    // R3: fill every word, loads back to back with data phases
    for (int i = 0; i < DEPTH; i++) begin
      set_in(0, 0, 0, 0, i, (i == 0) ? '1 : '0, (i == 0) ? '0 : pat(i - 1));
      cyc("R3_fill");
    end
    sel_all(0, 1, 0);
    set_in(0, 0, 1, 0, 0, '0, pat(DEPTH - 1));
    cyc("R3_last");
    sel_all(1, 1, 0);

    // R2: single reads
    set_in(0, 0, 1, 0, 5, '1, '0);  cyc("R2_read5");
    set_in(0, 0, 1, 0, 63, '1, '0); cyc("R2_read63");

    // R4: deselect via each chip enable, with a write that must not land
    sel_all(1, 1, 1);
    set_in(0, 0, 0, 0, 20, '1, '0); cyc("R4_desel_lo");
    set_in(0, 1, 0, 0, 0, '0, 36'hFFFFFFFFF); cyc("R4_desel_adv");
    sel_all(0, 1, 0);
    set_in(0, 0, 0, 0, 20, '0, 36'h0); cyc("R4_desel_a");
    sel_all(1, 0, 0);
    set_in(0, 0, 1, 0, 20, '0, 36'h0); cyc("R4_desel_b");
    sel_all(1, 1, 0);
    set_in(0, 0, 1, 0, 20, '0, 36'h0); cyc("R4_readback");

    // R3 + R9: partial write then immediate read of same word
    set_in(0, 0, 0, 0, 7, '1, '0);                  cyc("R3_ldwr7");
    set_in(0, 0, 1, 0, 7, 4'b1010, 36'h0_1234_5678); cyc("R9_bypass7");
    set_in(0, 0, 1, 0, 7, '1, '0);                  cyc("R3_reread7");

    // R10: alternating write/read every cycle
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) set_in(0, 0, 0, 0, 10 + k, '1, pat(100 + k));
      else            set_in(0, 0, 1, 0, 10 + k - 1, 4'b0110, pat(200 + k));
      cyc("R10_alt");
    end
    set_in(0, 0, 1, 0, 12, '1, '0); cyc("R10_check");

    // R5: linear burst from low bits 2, run past a wrap
    set_in(0, 0, 1, 0, 18, '1, '0); cyc("R5_load");
    for (int k = 0; k < 5; k++) begin
      set_in(0, 1, 0, 1, 0, '1, '0); cyc("R5_adv");
    end

    // R6: interleaved burst from low bits 1
    set_in(0, 0, 1, 1, 33, '1, '0); cyc("R6_load");
    for (int k = 0; k < 3; k++) begin
      set_in(0, 1, 1, 0, 0, '1, '0); cyc("R6_adv");
    end
    set_in(0, 0, 1, 1, 46, '1, '0); cyc("R6_load2");
    for (int k = 0; k < 3; k++) begin
      set_in(0, 1, 0, 0, 0, '1, '0); cyc("R6_adv2");
    end

    // R7: write burst, advances carry wr_n=1 and a deselecting chip enable
    set_in(0, 0, 0, 0, 40, '1, '0); cyc("R7_ldwr");
    sel_all(0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      set_in(0, 1, 1, 1, 0, '0, pat(300 + k)); cyc("R7_adv");
    end
    sel_all(1, 1, 0);
    set_in(0, 0, 1, 0, 40, '0, pat(399)); cyc("R7_rd_load");
    for (int k = 0; k < 3; k++) begin
      set_in(0, 1, 0, 0, 0, '1, '0); cyc("R7_rd_adv");
    end

    // R8: suspend in mid read burst with hostile inputs
    set_in(0, 0, 1, 0, 24, '1, '0); cyc("R8_load");
    set_in(0, 1, 1, 0, 0, '1, '0);  cyc("R8_adv");
    for (int k = 0; k < 3; k++) begin
      set_in(1, 0, 0, 1, 3, '0, 36'hFFFFFFFFF); cyc("R8_hold");
    end
    set_in(0, 1, 1, 0, 0, '1, '0); cyc("R8_resume");
    // suspend between a write load and its data phase
    set_in(0, 0, 0, 0, 50, '1, '0); cyc("R8_ldwr");
    for (int k = 0; k < 2; k++) begin
      set_in(1, 1, 1, 0, 0, '0, 36'h0); cyc("R8_hold_wr");
    end
    set_in(0, 0, 1, 0, 50, '0, pat(500)); cyc("R8_wdata");
    set_in(0, 0, 1, 0, 51, '1, '0);       cyc("R8_neighbour");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule